// File: doc/BRIEF.md
# Outstanding Load-Miss Tracker

This block sits beside a data cache and keeps track of load misses that are waiting for memory, so the core can keep hitting in the cache while earlier misses are still being fetched. It has two linked tables. The primary table holds one entry per distinct missing line (or per uncached load) and sends exactly one request to the bus for each. The secondary table holds later misses that fall into a line whose primary entry is still waiting. These misses are attached to that primary entry, so they cause no extra bus traffic.

When the bus answers a primary entry, the block emits a stream of completions. The first completion carries the primary's destination tag. After it comes one completion for each attached secondary, oldest first, and all of them carry the returned data. When the stream ends, the entries are freed. The core is stalled only when the table that a new miss needs is full. A drain command stops new misses from being accepted and reports done once both tables are empty.

All three data paths use valid/ready. A miss is taken only in a cycle with `miss_valid` and `miss_ready` both high. `miss_ready` is combinational on the presented address and uncached flag. A bus request, once shown, keeps its address and id until `bus_req_ready` is seen. A response is taken only while `bus_rsp_ready` is high, which means no completion stream is in progress. A completion keeps its tag and data until `cpl_ready` is seen.

Top module: `miss_tracker`

## Requirements
- R1: After reset, `bus_req_valid`, `cpl_valid`, `stall` and `drain_done` are low, and a presented miss is accepted.
- R2: An accepted cached miss to a line with no waiting primary creates one bus request. Its address is the miss address with the line-offset bits (bits 4:0 for 32-byte lines) cleared, and `bus_req_uncached` is low. The request's `bus_req_id` is later used as `bus_rsp_id`. A request that is shown but not accepted keeps the same address and id in the next cycle.
- R3: A cached miss whose line matches a primary entry that is not yet being filled goes into the secondary table and creates no bus request.
- R4: Up to four primary entries may be outstanding. A miss that needs a new primary entry while four are busy sees `miss_ready` low and `stall` high.
- R5: Up to four secondary entries may be outstanding. A merging miss that arrives while all four are busy sees `miss_ready` low and `stall` high.
- R6: An uncached miss never merges. It always takes its own primary entry, and its bus request carries the full byte address with `bus_req_uncached` high.
- R7: For each accepted response, the completions come in this order: first the primary tag, then the tag of each attached secondary in the order those misses were accepted. Every one of them carries `bus_rsp_data`.
- R8: `bus_rsp_ready` is low from the cycle after a response is accepted until its completion stream has ended.
- R9: While `drain_req` is high, no miss is accepted. `drain_done` rises exactly one cycle after both tables have become empty, and it is never high while any entry is outstanding.
- R10: A cached miss to a line whose response has already been accepted does not merge. It creates a new primary entry and a new bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | The presented miss is accepted this cycle |
| miss_addr | input | ADDR_W | Byte address of the missing load |
| miss_tag | input | TAG_W | Destination tag returned with the completion |
| miss_uncached | input | 1 | The load is non-cacheable |
| stall | output | 1 | A presented miss cannot be taken |
| bus_req_valid | output | 1 | Fetch request valid |
| bus_req_ready | input | 1 | Bus takes the request |
| bus_req_addr | output | ADDR_W | Line address, or the full address when uncached |
| bus_req_uncached | output | 1 | The request is for an uncached load |
| bus_req_id | output | PIW | Primary slot of the request |
| bus_rsp_valid | input | 1 | Fill data valid |
| bus_rsp_ready | output | 1 | Block can take a response |
| bus_rsp_id | input | PIW | Slot being answered |
| bus_rsp_data | input | DATA_W | Returned data |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Core takes the completion |
| cpl_tag | output | TAG_W | Destination tag being completed |
| cpl_data | output | DATA_W | Data for that destination |
| drain_req | input | 1 | Empty both tables and hold off new misses |
| drain_done | output | 1 | Both tables are empty while draining |

## Verification
A corrupt primary entry shows up at the bus port as soon as that entry is selected. It appears either as a request for a line that was never missed or as a second request for a line that is already outstanding. A lost or misdirected link between tables only shows when the owning line's response arrives. At that point the completion stream has a missing, extra or reordered tag, within a few cycles of `bus_rsp_ready` going low. Wrong occupancy counts show up on the very cycle a miss is presented, as a `miss_ready` or `stall` value that differs from what the table contents imply. A late or early `drain_done` is visible to the exact cycle against the last completion handshake.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  typedef enum logic [1:0] {
    CPL_IDLE = 2'd0,
    CPL_PRIM = 2'd1,
    CPL_SEC  = 2'd2
  } cpl_state_e;
endpackage

// File: rtl/mtb_primary.sv
module mtb_primary #(
  parameter int N     = 4,
  parameter int AW    = 32,
  parameter int OFF_W = 5,
  parameter int TW    = 6,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] in_addr,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx,
  output logic          full,
  output logic          empty,
  input  logic          alloc_en,
  input  logic          alloc_unc,
  input  logic [TW-1:0] alloc_tag,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_unc,
  output logic [IW-1:0] req_id,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic          free_en,
  input  logic [IW-1:0] free_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [TW-1:0] rd_tag,
  output logic [N-1:0]  valid_o
);
  localparam int LW = AW - OFF_W;

  logic [N-1:0]  valid_q, sent_q, fill_q, unc_q;
  logic [AW-1:0] addr_q [N];
  logic [TW-1:0] tag_q  [N];
  logic          lock_q;
  logic [IW-1:0] lock_idx_q;

  logic [N-1:0]  hit_vec, pend_vec;
  logic [IW-1:0] free_slot, pend_idx;
  logic          pend_any;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit_vec[i]  = valid_q[i] && !fill_q[i] && !unc_q[i] &&
                    (addr_q[i][AW-1:OFF_W] == in_addr[AW-1:OFF_W]);
      pend_vec[i] = valid_q[i] && !sent_q[i];
    end
  end

  always_comb begin
    lk_idx    = '0;
    free_slot = '0;
    pend_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i])   lk_idx    = IW'(i);
      if (!valid_q[i])  free_slot = IW'(i);
      if (pend_vec[i])  pend_idx  = IW'(i);
    end
  end

  assign lk_hit   = |hit_vec;
  assign full     = &valid_q;
  assign empty    = ~|valid_q;
  assign pend_any = |pend_vec;
  assign valid_o  = valid_q;

  assign req_valid = lock_q || pend_any;
  assign req_id    = lock_q ? lock_idx_q : pend_idx;
  assign req_unc   = unc_q[req_id];
  assign req_addr  = unc_q[req_id] ? addr_q[req_id]
                                   : {addr_q[req_id][AW-1:OFF_W], {OFF_W{1'b0}}};
  assign rd_tag    = tag_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= req_valid && !req_ready;
      lock_idx_q <= req_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      sent_q  <= '0;
      fill_q  <= '0;
      unc_q   <= '0;
      for (int i = 0; i < N; i++) begin
        addr_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      if (req_valid && req_ready) sent_q[req_id] <= 1'b1;
      if (fill_en)                fill_q[fill_idx] <= 1'b1;
      if (free_en) begin
        valid_q[free_idx] <= 1'b0;
        sent_q[free_idx]  <= 1'b0;
        fill_q[free_idx]  <= 1'b0;
      end
      if (alloc_en) begin
        valid_q[free_slot] <= 1'b1;
        sent_q[free_slot]  <= 1'b0;
        fill_q[free_slot]  <= 1'b0;
        unc_q[free_slot]   <= alloc_unc;
        addr_q[free_slot]  <= in_addr;
        tag_q[free_slot]   <= alloc_tag;
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_id));

  // R2
  fill_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> valid_q[fill_idx] && sent_q[fill_idx] && !fill_q[fill_idx]);

  // R4
  alloc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> $countones(valid_q) >= 1);

  logic unused_lw;
  assign unused_lw = (LW > 0);
endmodule

// File: rtl/mtb_secondary.sv
module mtb_secondary #(
  parameter int N   = 4,
  parameter int PIW = 2,
  parameter int SIW = 2,
  parameter int TW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_en,
  input  logic [PIW-1:0]          alloc_pidx,
  input  logic [TW-1:0]           alloc_tag,
  output logic                    full,
  output logic                    empty,
  input  logic                    q_en,
  input  logic [PIW-1:0]          q_pidx,
  output logic                    cand_hit,
  output logic [SIW-1:0]          cand_idx,
  output logic [TW-1:0]           cand_tag,
  input  logic                    free_en,
  input  logic [SIW-1:0]          free_idx,
  output logic [N-1:0]            valid_o,
  output logic [N-1:0][PIW-1:0]   pidx_o
);
  logic [N-1:0]   valid_q;
  logic [PIW-1:0] pidx_q  [N];
  logic [TW-1:0]  tag_q   [N];
  logic [N-1:0]   older_q [N];

  logic [N-1:0]   cand, oldest;
  logic [SIW-1:0] free_slot;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cand[i] = q_en && valid_q[i] && (pidx_q[i] == q_pidx);
    end
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int k = 0; k < N; k++) begin
        if (cand[k] && older_q[k][i]) beaten = 1'b1;
      end
      oldest[i] = cand[i] && !beaten;
    end
  end

  always_comb begin
    cand_idx  = '0;
    free_slot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (oldest[i])   cand_idx  = SIW'(i);
      if (!valid_q[i]) free_slot = SIW'(i);
    end
  end

  assign cand_hit = |cand;
  assign cand_tag = tag_q[cand_idx];
  assign full     = &valid_q;
  assign empty    = ~|valid_q;
  assign valid_o  = valid_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pidx
      assign pidx_o[g] = pidx_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) begin
        pidx_q[i]  <= '0;
        tag_q[i]   <= '0;
        older_q[i] <= '0;
      end
    end else begin
      if (free_en) valid_q[free_idx] <= 1'b0;
      if (alloc_en) begin
        valid_q[free_slot] <= 1'b1;
        pidx_q[free_slot]  <= alloc_pidx;
        tag_q[free_slot]   <= alloc_tag;
        older_q[free_slot] <= '0;
        for (int i = 0; i < N; i++) begin
          if (SIW'(i) != free_slot) older_q[i][free_slot] <= valid_q[i];
        end
      end
    end
  end

  // R7
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_hit |-> $onehot0(oldest) && (oldest != '0));

  // R5
  sec_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en && !free_en |=> $countones(valid_q) == $past($countones(valid_q)) + 1);
endmodule

// File: rtl/mtb_complete.sv
module mtb_complete
  import mtb_pkg::*;
#(
  parameter int PIW = 2,
  parameter int SIW = 2,
  parameter int TW  = 6,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [PIW-1:0] rsp_id,
  input  logic [DW-1:0]  rsp_data,
  output logic           fill_en,
  output logic [PIW-1:0] cur_idx,
  input  logic [TW-1:0]  prim_tag,
  output logic           q_en,
  input  logic           cand_hit,
  input  logic [SIW-1:0] cand_idx,
  input  logic [TW-1:0]  cand_tag,
  output logic           sec_free_en,
  output logic [SIW-1:0] sec_free_idx,
  output logic           prim_free_en,
  output logic           cpl_valid,
  input  logic           cpl_ready,
  output logic [TW-1:0]  cpl_tag,
  output logic [DW-1:0]  cpl_data
);
  cpl_state_e    state_q, state_d;
  logic [PIW-1:0] idx_q;
  logic [DW-1:0]  data_q;

  assign rsp_ready    = (state_q == CPL_IDLE);
  assign fill_en      = rsp_valid && rsp_ready;
  assign cur_idx      = idx_q;
  assign cpl_data     = data_q;
  assign sec_free_idx = cand_idx;

  always_comb begin
    state_d      = state_q;
    q_en         = 1'b0;
    cpl_valid    = 1'b0;
    cpl_tag      = prim_tag;
    sec_free_en  = 1'b0;
    prim_free_en = 1'b0;
    case (state_q)
      CPL_IDLE: if (fill_en) state_d = CPL_PRIM;
      CPL_PRIM: begin
        cpl_valid = 1'b1;
        if (cpl_ready) state_d = CPL_SEC;
      end
      CPL_SEC: begin
        q_en = 1'b1;
        if (cand_hit) begin
          cpl_valid   = 1'b1;
          cpl_tag     = cand_tag;
          sec_free_en = cpl_ready;
        end else begin
          prim_free_en = 1'b1;
          state_d      = CPL_IDLE;
        end
      end
      default: state_d = CPL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CPL_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fill_en) begin
        idx_q  <= rsp_id;
        data_q <= rsp_data;
      end
    end
  end

  // R7
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_data));

  // R8
  rsp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !rsp_ready);
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 32,
  parameter int PRI_N      = 4,
  parameter int SEC_N      = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int PIW       = (PRI_N > 1) ? $clog2(PRI_N) : 1,
  localparam int SIW       = (SEC_N > 1) ? $clog2(SEC_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  input  logic              miss_uncached,
  output logic              stall,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              bus_req_uncached,
  output logic [PIW-1:0]    bus_req_id,
  input  logic              bus_rsp_valid,
  output logic              bus_rsp_ready,
  input  logic [PIW-1:0]    bus_rsp_id,
  input  logic [DATA_W-1:0] bus_rsp_data,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [DATA_W-1:0] cpl_data,
  input  logic              drain_req,
  output logic              drain_done
);
  logic                      p_hit, p_full, p_empty, s_full, s_empty;
  logic [PIW-1:0]            p_idx, cur_idx;
  logic                      use_sec, accept;
  logic                      fill_en, prim_free_en, sec_free_en, q_en;
  logic                      cand_hit;
  logic [SIW-1:0]            cand_idx, sec_free_idx;
  logic [TAG_W-1:0]          prim_tag, cand_tag;
  logic [PRI_N-1:0]          p_valid;
  logic [SEC_N-1:0]          s_valid;
  logic [SEC_N-1:0][PIW-1:0] s_pidx;
  logic                      drain_done_q;

  assign use_sec    = !miss_uncached && p_hit;
  assign miss_ready = !drain_req && (use_sec ? !s_full : !p_full);
  assign accept     = miss_valid && miss_ready;
  assign stall      = miss_valid && !miss_ready;
  assign drain_done = drain_done_q;

  mtb_primary #(.N(PRI_N), .AW(ADDR_W), .OFF_W(OFF_W), .TW(TAG_W), .IW(PIW)) prim_i (
    .clk(clk), .rst_n(rst_n),
    .in_addr(miss_addr), .lk_hit(p_hit), .lk_idx(p_idx),
    .full(p_full), .empty(p_empty),
    .alloc_en(accept && !use_sec), .alloc_unc(miss_uncached), .alloc_tag(miss_tag),
    .req_valid(bus_req_valid), .req_ready(bus_req_ready), .req_addr(bus_req_addr),
    .req_unc(bus_req_uncached), .req_id(bus_req_id),
    .fill_en(fill_en), .fill_idx(bus_rsp_id),
    .free_en(prim_free_en), .free_idx(cur_idx),
    .rd_idx(cur_idx), .rd_tag(prim_tag), .valid_o(p_valid)
  );

  mtb_secondary #(.N(SEC_N), .PIW(PIW), .SIW(SIW), .TW(TAG_W)) sec_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(accept && use_sec), .alloc_pidx(p_idx), .alloc_tag(miss_tag),
    .full(s_full), .empty(s_empty),
    .q_en(q_en), .q_pidx(cur_idx),
    .cand_hit(cand_hit), .cand_idx(cand_idx), .cand_tag(cand_tag),
    .free_en(sec_free_en), .free_idx(sec_free_idx),
    .valid_o(s_valid), .pidx_o(s_pidx)
  );

  mtb_complete #(.PIW(PIW), .SIW(SIW), .TW(TAG_W), .DW(DATA_W)) cpl_i (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(bus_rsp_valid), .rsp_ready(bus_rsp_ready),
    .rsp_id(bus_rsp_id), .rsp_data(bus_rsp_data),
    .fill_en(fill_en), .cur_idx(cur_idx), .prim_tag(prim_tag),
    .q_en(q_en), .cand_hit(cand_hit), .cand_idx(cand_idx), .cand_tag(cand_tag),
    .sec_free_en(sec_free_en), .sec_free_idx(sec_free_idx), .prim_free_en(prim_free_en),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag), .cpl_data(cpl_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drain_done_q <= 1'b0;
    else        drain_done_q <= drain_req && p_empty && s_empty;
  end

  logic orphan;
  always_comb begin
    orphan = 1'b0;
    for (int i = 0; i < SEC_N; i++) begin
      if (s_valid[i] && !p_valid[s_pidx[i]]) orphan = 1'b1;
    end
  end

  // R3
  link_live_chk: assert property (@(posedge clk) disable iff (!rst_n) !orphan);

  // R9
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !bus_req_valid && !cpl_valid && $past(drain_req));

  // R9
  drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && miss_valid |-> stall);
endmodule

// File: tb/miss_tracker_tb_top.sv
module miss_tracker_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        miss_valid = 0, miss_uncached = 0;
  logic [31:0] miss_addr = 0;
  logic [5:0]  miss_tag = 0;
  logic        miss_ready, stall;
  logic        bus_req_valid, bus_req_uncached, bus_req_ready = 0;
  logic [31:0] bus_req_addr;
  logic [1:0]  bus_req_id;
  logic        bus_rsp_valid = 0, bus_rsp_ready;
  logic [1:0]  bus_rsp_id = 0;
  logic [31:0] bus_rsp_data = 0;
  logic        cpl_valid, cpl_ready = 0;
  logic [5:0]  cpl_tag;
  logic [31:0] cpl_data;
  logic        drain_req = 0, drain_done;

  always #5 clk = ~clk;

  miss_tracker dut_i (.*);

  int nchk = 0, nerr = 0, tickn = 0;
  bit          rv[8], runc[8], rsent[8];
  logic [31:0] raddr[8];
  logic [5:0]  rptag[8], rsec[8][4];
  int          rid[8], rns[8];
  logic [5:0]  eq_tag[$];
  logic [31:0] eq_data[$];
  bit          rsp_go = 0;
  int          rsp_rec = 0;
  logic [31:0] rsp_dat = 0;
  int          cpl_mode = 0;
  bit          prev_wait = 0;
  logic [31:0] prev_addr = 0;
  logic [1:0]  prev_id = 0;
  int          last_cpl_tick = -10, first_done_tick = -1;
  logic [5:0]  tag_ctr = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find_line(logic [31:0] a);
    for (int r = 0; r < 8; r++)
      if (rv[r] && !runc[r] && raddr[r][31:5] == a[31:5]) return r;
    return -1;
  endfunction

  function automatic int n_rec();
    int n = 0;
    for (int r = 0; r < 8; r++) if (rv[r]) n++;
    return n;
  endfunction

  function automatic int n_sec();
    int n = 0;
    for (int r = 0; r < 8; r++) if (rv[r]) n += rns[r];
    return n;
  endfunction

  function automatic bit exp_ready(logic [31:0] a, bit u);
    if (drain_req) return 1'b0;
    if (!u && find_line(a) >= 0) return n_sec() < 4;
    return n_rec() < 4;
  endfunction

  function automatic logic [31:0] exp_baddr(logic [31:0] a, bit u);
    return u ? a : {a[31:5], 5'b0};
  endfunction

  task automatic tick(bit mv, logic [31:0] ma, logic [5:0] mt, bit mu);
    bit er;
    int r;
    string lab;
    @(negedge clk);
    tickn++;
    miss_valid = mv; miss_addr = ma; miss_tag = mt; miss_uncached = mu;
    bus_req_ready = ($urandom % 4) != 0;
    cpl_ready = (cpl_mode == 1) ? 1'b1 : (cpl_mode == 2) ? 1'b0 : (($urandom % 3) != 0);
    bus_rsp_valid = rsp_go;
    bus_rsp_id = rsp_go ? 2'(rid[rsp_rec]) : 2'd0;
    bus_rsp_data = rsp_dat;
    #1;
    if (prev_wait)
      chk(bus_req_valid && bus_req_addr == prev_addr && bus_req_id == prev_id,
          "R2", "held request", bus_req_addr, prev_addr);
    prev_wait = 0;
    if (mv) begin
      er  = exp_ready(ma, mu);
      lab = drain_req ? "R9" : (!mu && find_line(ma) >= 0) ? "R5" : "R4";
      chk(miss_ready == er, lab, "miss_ready", miss_ready, er);
      chk(stall == !er, lab, "stall", stall, !er);
      if (er) begin
        r = find_line(ma);
        if (!mu && r >= 0) begin
          rsec[r][rns[r]] = mt; rns[r]++;
        end else begin
          r = 0;
          while (rv[r]) r++;
          rv[r] = 1; raddr[r] = ma; runc[r] = mu; rptag[r] = mt; rsent[r] = 0; rns[r] = 0;
        end
      end
    end
    if (bus_req_valid) begin
      if (bus_req_ready) begin
        int f = -1;
        for (int k = 0; k < 8; k++)
          if (f < 0 && rv[k] && !rsent[k] && runc[k] == bus_req_uncached &&
              exp_baddr(raddr[k], runc[k]) == bus_req_addr) f = k;
        chk(f >= 0, "R2,R3", "request matches a waiting line", bus_req_addr, 0);
        if (f >= 0) begin rsent[f] = 1; rid[f] = bus_req_id; end
      end else begin
        prev_wait = 1; prev_addr = bus_req_addr; prev_id = bus_req_id;
      end
    end
    if (bus_rsp_valid) begin
      if (eq_tag.size() > 0) chk(!bus_rsp_ready, "R8", "rsp_ready during stream", bus_rsp_ready, 0);
      if (bus_rsp_ready) begin
        eq_tag.push_back(rptag[rsp_rec]); eq_data.push_back(rsp_dat);
        for (int s = 0; s < rns[rsp_rec]; s++) begin
          eq_tag.push_back(rsec[rsp_rec][s]); eq_data.push_back(rsp_dat);
        end
        rv[rsp_rec] = 0;
        rsp_go = 0;
      end
    end
    if (cpl_valid && cpl_ready) begin
      if (eq_tag.size() == 0) chk(0, "R7", "unexpected completion", cpl_tag, 0);
      else begin
        logic [5:0]  et = eq_tag.pop_front();
        logic [31:0] ed = eq_data.pop_front();
        chk(cpl_tag == et, "R7", "completion tag", cpl_tag, et);
        chk(cpl_data == ed, "R7", "completion data", cpl_data, ed);
      end
      last_cpl_tick = tickn;
    end
    if (drain_done) begin
      if (n_rec() > 0 || eq_tag.size() > 0)
        chk(0, "R9", "drain_done with work outstanding", drain_done, 0);
      if (drain_req && first_done_tick < 0) first_done_tick = tickn;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask

  task automatic miss(logic [31:0] a, bit u);
    tag_ctr++;
    tick(1, a, tag_ctr, u);
  endtask

  task automatic respond_one();
    int r = -1, w = 0;
    while (r < 0 && w < 100) begin
      int st = $urandom % 8;
      for (int k = 0; k < 8; k++)
        if (r < 0 && rv[(st + k) % 8] && rsent[(st + k) % 8]) r = (st + k) % 8;
      if (r < 0) begin idle(1); w++; end
    end
    if (r < 0) return;
    rsp_rec = r; rsp_dat = $urandom; rsp_go = 1;
    w = 0;
    while (rsp_go && w < 100) begin idle(1); w++; end
    w = 0;
    while (eq_tag.size() > 0 && w < 200) begin idle(1); w++; end
    idle(3);
  endtask

  task automatic respond_all();
    int w = 0;
    while (n_rec() > 0 && w < 50) begin respond_one(); w++; end
  endtask

  function automatic logic [31:0] line_addr(int l);
    return 32'h1000 + 32'(l) * 32 + 32'($urandom % 32);
  endfunction

  initial begin
    #1500000;
    nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin rv[r] = 0; rns[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req_valid, "R1", "bus_req_valid", bus_req_valid, 0);
    chk(!cpl_valid, "R1", "cpl_valid", cpl_valid, 0);
    chk(!stall, "R1", "stall", stall, 0);
    chk(!drain_done, "R1", "drain_done", drain_done, 0);

    // R4: four distinct lines, then a fifth stalls
    for (int l = 0; l < 4; l++) miss(line_addr(l), 0);
    miss(line_addr(4), 0);
    chk(n_rec() == 4, "R4", "primary occupancy", n_rec(), 4);
    // R5: fill the secondary table, fifth merging miss stalls
    for (int s = 0; s < 4; s++) miss(line_addr(s % 2), 0);
    miss(line_addr(1), 0);
    chk(n_sec() == 4, "R5", "secondary occupancy", n_sec(), 4);
    miss(line_addr(0), 1);
    idle(8);
    respond_all();

    // R6: two uncached loads to one address take two entries
    begin
      logic [31:0] ua = line_addr(2);
      miss(ua, 1);
      miss(ua, 1);
      chk(n_rec() == 2, "R6", "uncached entries", n_rec(), 2);
      idle(12);
      chk(rsent[0] && rsent[1], "R6", "uncached requests sent", {rsent[0], rsent[1]}, 2'b11);
      respond_all();
    end

    // R10: a miss to a line already being filled opens a new primary
    begin
      logic [31:0] la = line_addr(5);
      int w = 0;
      miss(la, 0);
      while (!rsent[0] && w < 50) begin idle(1); w++; end
      cpl_mode = 2;
      rsp_rec = 0; rsp_dat = $urandom; rsp_go = 1;
      w = 0;
      while (rsp_go && w < 50) begin idle(1); w++; end
      miss(la, 0);
      idle(12);
      chk(n_rec() == 1 && rsent[find_line(la)], "R10", "second request for filling line",
          n_rec(), 1);
      cpl_mode = 0;
      w = 0;
      while (eq_tag.size() > 0 && w < 100) begin idle(1); w++; end
      idle(3);
      respond_all();
    end

    // random rounds
    for (int rnd = 0; rnd < 40; rnd++) begin
      for (int c = 0; c < 10; c++) begin
        if (($urandom % 10) < 7) miss(line_addr($urandom % 6), ($urandom % 5) == 0);
        else idle(1);
      end
      idle(6);
      begin
        int nr = 1 + ($urandom % 4);
        for (int k = 0; k < nr; k++) respond_one();
      end
    end
    respond_all();

    // R9: drain with work outstanding
    for (int l = 0; l < 3; l++) miss(line_addr(l), 0);
    miss(line_addr(0), 0);
    idle(10);
    drain_req = 1;
    miss(line_addr(7), 0);
    miss(line_addr(1), 0);
    chk(!drain_done, "R9", "drain_done before empty", drain_done, 0);
    respond_all();
    idle(4);
    chk(first_done_tick == last_cpl_tick + 3, "R9", "drain_done timing",
        first_done_tick, last_cpl_tick + 3);
    chk(drain_done, "R9", "drain_done held", drain_done, 1);
    drain_req = 0;
    idle(2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule